// File: doc/BRIEF.md
# Translation Page-Size and Purge Request Validator

This block screens requests headed for a translation cache. Each request is an insert, a local purge or a purge broadcast by another processor. Every request carries a 6-bit page-size exponent N (a page covers 2^N bytes), a virtual address and a physical address. The block answers each request one cycle later with an accept bit, a fault code and, for purges, an address mask or a purge-everything command. The cache storage is outside the block.

Inserts and purges accept different sets of page sizes. An insert also needs both of its addresses to sit on the natural boundary of the page. A purge with an unsupported size is handled by a build-time policy: abort, drop the request, or flush the whole cache. A purge broadcast by another processor is never allowed to abort. Under the abort policy such a purge is turned into a full flush.

Top module: `pgsz_guard`

## Requirements
- R1: Inserts accept size exponents 12, 13, 14, 16, 18, 20, 22, 24, 26 and 28. An insert with any other exponent responds with accept 0 and code 1 (reserved-field fault). An accepted insert responds with code 0, purge_all 0 and a mask of 0.
- R2: For an insert whose size is accepted, both addresses must have their low N bits equal to zero. Otherwise the response is accept 0 with code 2 (alignment fault). A size fault takes priority over an alignment fault.
- R3: Purges accept the insert sizes plus exponent 32. A legal purge responds with accept 1, code 0, purge_all 0 and purge_mask equal to all ones with the low N bits cleared. Purge addresses are not checked for alignment.
- R4: With POLICY 0, a local purge (kind 2'b01) of an unsupported size responds with accept 0 and code 3 (machine-check abort).
- R5: With POLICY 1, a purge of an unsupported size is dropped: accept 0, code 0, purge_all 0, mask 0.
- R6: With POLICY 2 or 3, a purge of an unsupported size responds with accept 1, code 0, purge_all 1 and a mask of 0.
- R7: A remote purge never yields code 3. With POLICY 0, an unsupported remote purge size yields the purge-all response described in R6.
- R8: rsp_vld equals req_vld of the previous cycle. While rsp_vld is 0, the outputs rsp_ok, rsp_code, purge_all and purge_mask are all 0.
- R9: Kind encoding: 2'b00 is an insert, 2'b01 is a local purge, and both 2'b10 and 2'b11 are remote purges.
- R10: During reset and in the first cycle after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| req_kind | input | 2 | Request kind (R9) |
| req_ps | input | 6 | Page-size exponent N |
| req_vaddr | input | ADDR_W | Virtual address |
| req_paddr | input | PADDR_W | Physical address |
| rsp_vld | output | 1 | Response strobe, one cycle after req_vld |
| rsp_ok | output | 1 | Request accepted |
| rsp_code | output | 2 | 0 none, 1 reserved field, 2 alignment, 3 machine-check abort |
| purge_all | output | 1 | Flush every cache entry |
| purge_mask | output | ADDR_W | Purge address mask, low N bits cleared |

## Verification
The assertions assume that req_kind and req_ps are stable and known whenever req_vld is high. Some properties refer to the previous cycle's request. They also assume that reset is held long enough for the output registers to clear. The bench drives every input on the falling clock edge and holds reset with req_vld low. It applies every kind together with every exponent from 0 to 63, so the size sets are covered in full and no exponent falls outside the field. For purges it uses addresses of any alignment, which confirms that alignment affects only inserts.

// File: rtl/pgsz_pkg.sv
package pgsz_pkg;

  localparam int PS_W   = 6;
  localparam int MASK_W = 64;

  typedef enum logic [1:0] {
    CODE_NONE  = 2'd0,
    CODE_RSVD  = 2'd1,
    CODE_ALIGN = 2'd2,
    CODE_MCA   = 2'd3
  } code_e;

  localparam logic [1:0] KIND_INSERT = 2'b00;
  localparam logic [1:0] KIND_LPURGE = 2'b01;

  localparam int POL_ABORT  = 0;
  localparam int POL_IGNORE = 1;

  // Sizes that may be placed in the cache: 4K, 8K, 16K, then every
  // power of four from 64K to 256M.
  function automatic logic ps_insertable(input logic [PS_W-1:0] ps);
    logic small_ok, even_ok;
    small_ok = (ps >= 6'd12) && (ps <= 6'd14);
    even_ok  = (ps >= 6'd16) && (ps <= 6'd28) && !ps[0];
    return small_ok || even_ok;
  endfunction

  // Purges also cover the 4G page.
  function automatic logic ps_purgeable(input logic [PS_W-1:0] ps);
    return ps_insertable(ps) || (ps == 6'd32);
  endfunction

  // Ones in the N low positions.
  function automatic logic [MASK_W-1:0] low_ones(input logic [PS_W-1:0] ps);
    return (64'h1 << ps) - 64'h1;
  endfunction

endpackage

// File: rtl/pgsz_classify.sv
module pgsz_classify
  import pgsz_pkg::*;
(
  input  logic [1:0]      kind,
  input  logic [PS_W-1:0] ps,
  output logic            is_insert,
  output logic            is_remote,
  output logic            size_ok,
  output logic            ill_purge
);
  logic ins_ok, prg_ok;

  assign is_insert = (kind == KIND_INSERT);
  assign is_remote = kind[1];
  assign ins_ok    = ps_insertable(ps);
  assign prg_ok    = ps_purgeable(ps);
  assign size_ok   = is_insert ? ins_ok : prg_ok;
  assign ill_purge = !is_insert && !prg_ok;
endmodule

// File: rtl/pgsz_align.sv
module pgsz_align
  import pgsz_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int PADDR_W = 50
) (
  input  logic [PS_W-1:0]    ps,
  input  logic [ADDR_W-1:0]  vaddr,
  input  logic [PADDR_W-1:0] paddr,
  output logic               misaligned,
  output logic [ADDR_W-1:0]  page_mask
);
  logic [MASK_W-1:0] ones;
  logic              v_off, p_off;

  assign ones       = low_ones(ps);
  assign v_off      = |(vaddr & ones[ADDR_W-1:0]);
  assign p_off      = |(paddr & ones[PADDR_W-1:0]);
  assign misaligned = v_off || p_off;
  assign page_mask  = ~ones[ADDR_W-1:0];
endmodule

// File: rtl/pgsz_resolve.sv
module pgsz_resolve
  import pgsz_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int POLICY = 0
) (
  input  logic              is_insert,
  input  logic              is_remote,
  input  logic              size_ok,
  input  logic              misaligned,
  input  logic [ADDR_W-1:0] page_mask,
  output logic              ok,
  output code_e             code,
  output logic              flush,
  output logic [ADDR_W-1:0] mask,
  output logic              demote
);
  // Response to a purge of an unsupported size, chosen by POLICY.
  logic  bad_ok, bad_flush;
  code_e bad_code;

  generate
    if (POLICY == POL_ABORT) begin : g_abort
      // A broadcast purge must not abort, so it falls back to a flush.
      assign bad_ok    = is_remote;
      assign bad_flush = is_remote;
      assign bad_code  = is_remote ? CODE_NONE : CODE_MCA;
      assign demote    = is_remote && !is_insert && !size_ok;
    end else if (POLICY == POL_IGNORE) begin : g_ignore
      assign bad_ok    = 1'b0;
      assign bad_flush = 1'b0;
      assign bad_code  = CODE_NONE;
      assign demote    = 1'b0;
    end else begin : g_flush
      assign bad_ok    = 1'b1;
      assign bad_flush = 1'b1;
      assign bad_code  = CODE_NONE;
      assign demote    = 1'b0;
    end
  endgenerate

  always_comb begin
    ok    = 1'b0;
    code  = CODE_NONE;
    flush = 1'b0;
    mask  = '0;
    if (is_insert) begin
      if (!size_ok)        code = CODE_RSVD;
      else if (misaligned) code = CODE_ALIGN;
      else                 ok   = 1'b1;
    end else if (size_ok) begin
      ok   = 1'b1;
      mask = page_mask;
    end else begin
      ok    = bad_ok;
      code  = bad_code;
      flush = bad_flush;
    end
  end
endmodule

// File: rtl/pgsz_guard.sv
module pgsz_guard
  import pgsz_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int PADDR_W = 50,
  parameter int POLICY  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_vld,
  input  logic [1:0]         req_kind,
  input  logic [5:0]         req_ps,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic [PADDR_W-1:0] req_paddr,
  output logic               rsp_vld,
  output logic               rsp_ok,
  output logic [1:0]         rsp_code,
  output logic               purge_all,
  output logic [ADDR_W-1:0]  purge_mask
);
  // Named internal events, observed by the checker.
  logic              is_insert, is_remote, size_ok, ill_purge_evt;
  logic              misaligned, demote_evt;
  logic [ADDR_W-1:0] page_mask, nxt_mask;
  logic              nxt_ok, nxt_flush;
  code_e             nxt_code;

  pgsz_classify u_cls (
    .kind      (req_kind),
    .ps        (req_ps),
    .is_insert (is_insert),
    .is_remote (is_remote),
    .size_ok   (size_ok),
    .ill_purge (ill_purge_evt)
  );

  pgsz_align #(.ADDR_W(ADDR_W), .PADDR_W(PADDR_W)) u_aln (
    .ps         (req_ps),
    .vaddr      (req_vaddr),
    .paddr      (req_paddr),
    .misaligned (misaligned),
    .page_mask  (page_mask)
  );

  pgsz_resolve #(.ADDR_W(ADDR_W), .POLICY(POLICY)) u_res (
    .is_insert  (is_insert),
    .is_remote  (is_remote),
    .size_ok    (size_ok),
    .misaligned (misaligned),
    .page_mask  (page_mask),
    .ok         (nxt_ok),
    .code       (nxt_code),
    .flush      (nxt_flush),
    .mask       (nxt_mask),
    .demote     (demote_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld    <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_code   <= CODE_NONE;
      purge_all  <= 1'b0;
      purge_mask <= '0;
    end else begin
      rsp_vld    <= req_vld;
      rsp_ok     <= req_vld && nxt_ok;
      rsp_code   <= req_vld ? nxt_code : CODE_NONE;
      purge_all  <= req_vld && nxt_flush;
      purge_mask <= req_vld ? nxt_mask : '0;
    end
  end
endmodule

// File: rtl/pgsz_guard_chk.sv
module pgsz_guard_chk
  import pgsz_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int POLICY = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic [1:0]        req_kind,
  input logic [5:0]        req_ps,
  input logic              rsp_vld,
  input logic              rsp_ok,
  input logic [1:0]        rsp_code,
  input logic              purge_all,
  input logic [ADDR_W-1:0] purge_mask,
  input logic              ill_purge_evt,
  input logic              demote_evt
);
  a_r8_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rsp_vld == $past(req_vld)));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> (!rsp_ok && !purge_all && rsp_code == 2'd0 && purge_mask == '0));

  a_r6_flush_shape: assert property (@(posedge clk) disable iff (!rst_n)
    purge_all |-> (rsp_ok && purge_mask == '0));

  a_r1_ok_no_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> (rsp_code == 2'd0));

  a_r7_no_remote_mca: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rsp_vld && $past(req_kind[1])) |-> (rsp_code != 2'd3));

  a_r4_mca_local_only: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rsp_vld && rsp_code == 2'd3) |->
      ($past(req_kind) == KIND_LPURGE && POLICY == POL_ABORT));

  a_r1_insert_size: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && rsp_ok && !purge_all && $past(req_kind) == KIND_INSERT)
      |-> $past(ps_insertable(req_ps)));

  a_r5_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && ill_purge_evt && POLICY == POL_IGNORE) |=>
      (rsp_vld && !rsp_ok && !purge_all && rsp_code == 2'd0));

  a_r7_demote_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && demote_evt) |=> (rsp_vld && purge_all));
endmodule

bind pgsz_guard pgsz_guard_chk #(.ADDR_W(ADDR_W), .POLICY(POLICY)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_vld       (req_vld),
  .req_kind      (req_kind),
  .req_ps        (req_ps),
  .rsp_vld       (rsp_vld),
  .rsp_ok        (rsp_ok),
  .rsp_code      (rsp_code),
  .purge_all     (purge_all),
  .purge_mask    (purge_mask),
  .ill_purge_evt (ill_purge_evt),
  .demote_evt    (demote_evt)
);

// File: tb/sim_pgsz_guard.sv
`timescale 1ns/1ps
module sim_pgsz_guard;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [5:0]  req_ps = 6'd0;
  logic [63:0] req_vaddr = '0;
  logic [49:0] req_paddr = '0;

  logic        o_vld [NP];
  logic        o_ok  [NP];
  logic [1:0]  o_code[NP];
  logic        o_all [NP];
  logic [63:0] o_mask[NP];

  logic        e_vld [NP];
  logic        e_ok  [NP];
  logic [1:0]  e_code[NP];
  logic        e_all [NP];
  logic [63:0] e_mask[NP];
  string       e_tag [NP];

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  for (genvar i = 0; i < NP; i++) begin : g_pol
    pgsz_guard #(.ADDR_W(64), .PADDR_W(50), .POLICY(i)) u0 (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_kind(req_kind),
      .req_ps(req_ps), .req_vaddr(req_vaddr), .req_paddr(req_paddr),
      .rsp_vld(o_vld[i]), .rsp_ok(o_ok[i]), .rsp_code(o_code[i]),
      .purge_all(o_all[i]), .purge_mask(o_mask[i]));
  end

  function automatic bit can_insert(int n);
    int sizes[10] = '{12, 13, 14, 16, 18, 20, 22, 24, 26, 28};
    foreach (sizes[j]) if (sizes[j] == n) return 1;
    return 0;
  endfunction

  // Behavioural expectation for one policy and the request now driven.
  task automatic model(int pol, bit v, logic [1:0] k, int n,
                       logic [63:0] va, logic [49:0] pa);
    logic [63:0] lowbits;
    bit off, ins, remote;
    lowbits = ~(~64'h0 << n);
    off = ((va & lowbits) != 0) || (({14'h0, pa} & lowbits) != 0);
    ins = (k == 2'b00);
    remote = (k >= 2);
    e_vld[pol] = v; e_ok[pol] = 0; e_code[pol] = 0; e_all[pol] = 0; e_mask[pol] = 0;
    if (!v) begin
      e_tag[pol] = "R8";
    end else if (ins) begin
      if (!can_insert(n)) begin e_code[pol] = 1; e_tag[pol] = "R1"; end
      else if (off) begin e_code[pol] = 2; e_tag[pol] = "R2"; end
      else begin e_ok[pol] = 1; e_tag[pol] = "R1"; end
    end else if (can_insert(n) || n == 32) begin
      e_ok[pol] = 1; e_mask[pol] = ~64'h0 << n;
      e_tag[pol] = (k == 2'b11) ? "R9" : "R3";
    end else if (pol == 0 && !remote) begin
      e_code[pol] = 3; e_tag[pol] = "R4";
    end else if (pol == 1) begin
      e_tag[pol] = "R5";
    end else begin
      e_ok[pol] = 1; e_all[pol] = 1;
      e_tag[pol] = (pol == 0) ? "R7" : "R6";
    end
  endtask

  task automatic check_all();
    for (int i = 0; i < NP; i++) begin
      checks++;
      if (o_vld[i] !== e_vld[i] || o_ok[i] !== e_ok[i] || o_code[i] !== e_code[i] ||
          o_all[i] !== e_all[i] || o_mask[i] !== e_mask[i]) begin
        errors++;
        $display("FAIL %s pol=%0d got vld=%b ok=%b code=%0d all=%b mask=%h exp vld=%b ok=%b code=%0d all=%b mask=%h",
                 e_tag[i], i, o_vld[i], o_ok[i], o_code[i], o_all[i], o_mask[i],
                 e_vld[i], e_ok[i], e_code[i], e_all[i], e_mask[i]);
      end
    end
  endtask

  task automatic drive(bit v, logic [1:0] k, int n, logic [63:0] va, logic [49:0] pa);
    @(negedge clk);
    check_all();
    req_vld = v; req_kind = k; req_ps = 6'(n); req_vaddr = va; req_paddr = pa;
    for (int i = 0; i < NP; i++) model(i, v, k, n, va, pa);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < NP; i++) begin
      e_vld[i] = 0; e_ok[i] = 0; e_code[i] = 0; e_all[i] = 0; e_mask[i] = 0;
      e_tag[i] = "R10";
    end
    repeat (3) @(negedge clk);
    check_all();                       // R10 reset state
    rst_n = 1'b1;
    // Full sweep of kinds and exponents with aligned addresses (R1 R3 R4..R7 R9).
    for (int k = 0; k < 4; k++) begin
      for (int n = 0; n < 64; n++) begin
        logic [63:0] va;
        va = rnd64() & (~64'h0 << n);
        drive(1, 2'(k), n, va, 50'(va));
      end
    end
    // R2: misaligned inserts, virtual side then physical side.
    for (int n = 12; n <= 28; n++) begin
      logic [63:0] a;
      a = rnd64() & (~64'h0 << n);
      drive(1, 2'b00, n, a | (64'h1 << (n - 1)), 50'(a));
      drive(1, 2'b00, n, a, 50'(a) | (50'h1 << (n - 1)));
      drive(1, 2'b00, n, a | 64'h1, 50'(a));
      drive(0, 2'b00, n, a | 64'h1, 50'(a));   // R8 idle cycle
    end
    // R2 priority: bad size and misaligned gives the size fault.
    drive(1, 2'b00, 15, 64'h1, 50'h1);
    drive(1, 2'b00, 32, 64'h3, 50'h0);
    // R3: purges with unaligned addresses are still accepted.
    drive(1, 2'b01, 20, 64'h123, 50'h7);
    drive(1, 2'b10, 32, 64'hFFFF, 50'h1);
    // Mixed random traffic with gaps (R8).
    for (int t = 0; t < 600; t++) begin
      int n;
      logic [63:0] va;
      n = $urandom_range(0, 63);
      if ($urandom_range(0, 3) == 0) n = 12 + 2 * $urandom_range(0, 10);
      va = rnd64();
      if ($urandom_range(0, 1) == 1) va = va & (~64'h0 << n);
      drive(($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)), n, va, 50'(va));
    end
    drive(0, 2'b00, 0, '0, '0);
    drive(0, 2'b00, 0, '0, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule